// File: doc/BRIEF.md
# Video Capture Window Generator

This block sits on the pixel-clock side of a video input path. It takes the raw horizontal and vertical sync inputs of a video source and produces a sample-enable strobe that marks which pixels fall inside a rectangle the host programs. Each sync input has its own polarity select, so the active edge can be either the rising or the falling transition. A pixel counter restarts on every active HSYNC edge. A line counter restarts on every active VSYNC edge and advances on every active HSYNC edge.

The window bounds come from a separate register bank as plain field values: a first and last pixel offset and a first and last line offset. All offsets are counted from the active sync edge. The pixel and line counts are also brought out, together with two alignment flags. One flag marks the first sampled pixel of every line. The other marks the pixels of the first sampled line of a field. Downstream packing logic uses these flags to align its data.

Top module: `vcap_window_gen`

## Requirements
- R1: After reset, and until the first active VSYNC edge has been seen, `sample_en_o`, `line_first_o` and `field_first_o` stay low whatever HSYNC does.
- R2: `hpol_i` = 0 makes the low-to-high HSYNC transition the active edge, and `hpol_i` = 1 makes the high-to-low transition the active edge. The other transition has no effect on the pixel or line count.
- R3: `vpol_i` chooses the active VSYNC edge with the same encoding as `hpol_i` (0 = rising, 1 = falling).
- R4: HSYNC is registered once. The pixel count on `pix_cnt_o` reads 0 after the second rising clock edge that samples the new HSYNC level. It then rises by one on every clock and holds at 1023 (all ones). It resets to 1023.
- R5: The line count on `line_cnt_o` reads 0 two clock edges after an active VSYNC transition has been sampled. It rises by one on each active HSYNC edge that does not coincide with an active VSYNC edge, holds at 1023, and resets to 1023.
- R6: Once armed, `sample_en_o` is high exactly when hstart ≤ pixel count ≤ hend and vstart ≤ line count ≤ vend. The output is combinational from the counters, and a start offset of 0 is allowed.
- R7: If hstart > hend or vstart > vend, `sample_en_o` never rises.
- R8: `line_first_o` is high exactly when `sample_en_o` is high and the pixel count equals hstart.
- R9: `field_first_o` is high exactly when `sample_en_o` is high and the line count equals vstart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| hsync_i | input | 1 | Raw horizontal sync |
| vsync_i | input | 1 | Raw vertical sync |
| hpol_i | input | 1 | Active HSYNC edge: 0 rising, 1 falling |
| vpol_i | input | 1 | Active VSYNC edge: 0 rising, 1 falling |
| hstart_i | input | 10 | First sampled pixel offset |
| hend_i | input | 10 | Last sampled pixel offset |
| vstart_i | input | 10 | First sampled line offset |
| vend_i | input | 10 | Last sampled line offset |
| pix_cnt_o | output | 10 | Pixel count since the active HSYNC edge |
| line_cnt_o | output | 10 | Line count since the active VSYNC edge |
| sample_en_o | output | 1 | Pixel lies inside the window |
| line_first_o | output | 1 | First sampled pixel of a line |
| field_first_o | output | 1 | Pixel of the first sampled line |

## Verification
A sync transition presented before clock edge k is captured at edge k, detected combinationally, and clears its counter at edge k+1. The counts and the window outputs therefore change two edges after the stimulus. The window outputs follow the counters in the same cycle, because they are combinational. The bench drives its inputs on the falling clock edge and runs a behavioural model on the rising edge. The model keeps the sampled sync history in queues. All five outputs are compared with the model on every falling edge, half a period after the registers settle, so each result is checked in the cycle it is due.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_sel_e;

   localparam int unsigned VCAP_MAX_W = 16;

   function automatic logic in_span(input logic [VCAP_MAX_W-1:0] val,
                                    input logic [VCAP_MAX_W-1:0] lo,
                                    input logic [VCAP_MAX_W-1:0] hi);
      return (val >= lo) && (val <= hi);
   endfunction

endpackage

// File: rtl/vcap_edge_det.sv
module vcap_edge_det
   import vcap_pkg::*;
(
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sync_i,
   input  logic pol_i,
   output logic edge_o
);
   logic smp_q;
   logic prv_q;
   edge_sel_e sel;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         smp_q <= 1'b0;
         prv_q <= 1'b0;
      end else begin
         smp_q <= sync_i;
         prv_q <= smp_q;
      end
   end

   assign sel = edge_sel_e'(pol_i);

   always_comb begin
      if (sel == EDGE_FALL) edge_o = prv_q & ~smp_q;
      else                  edge_o = ~prv_q & smp_q;
   end
endmodule

// File: rtl/vcap_counter.sv
module vcap_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             clr_i,
   input  logic             inc_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                         cnt_o <= CNT_MAX;
      else if (clr_i)                      cnt_o <= '0;
      else if (inc_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
   end

   AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> cnt_o == '0); // R4
   AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && cnt_o == CNT_MAX) |=> cnt_o == CNT_MAX); // R4
   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && inc_i && cnt_o != CNT_MAX) |=> cnt_o == $past(cnt_o) + 1'b1); // R5
endmodule

// File: rtl/vcap_window_cmp.sv
module vcap_window_cmp
   import vcap_pkg::*;
#(
   parameter int unsigned CNT_W = 10
) (
   input  logic             armed_i,
   input  logic [CNT_W-1:0] pix_i,
   input  logic [CNT_W-1:0] line_i,
   input  logic [CNT_W-1:0] hstart_i,
   input  logic [CNT_W-1:0] hend_i,
   input  logic [CNT_W-1:0] vstart_i,
   input  logic [CNT_W-1:0] vend_i,
   output logic             sample_en_o,
   output logic             line_first_o,
   output logic             field_first_o
);
   localparam int unsigned PAD = VCAP_MAX_W - CNT_W;

   logic h_in, v_in;

   assign h_in = in_span({{PAD{1'b0}}, pix_i},  {{PAD{1'b0}}, hstart_i}, {{PAD{1'b0}}, hend_i});
   assign v_in = in_span({{PAD{1'b0}}, line_i}, {{PAD{1'b0}}, vstart_i}, {{PAD{1'b0}}, vend_i});

   assign sample_en_o   = armed_i & h_in & v_in;
   assign line_first_o  = sample_en_o & (pix_i == hstart_i);
   assign field_first_o = sample_en_o & (line_i == vstart_i);

   always_comb begin
      AST_EMPTY_WIN: assert (!(sample_en_o && ((hstart_i > hend_i) || (vstart_i > vend_i)))); // R7
   end
endmodule

// File: rtl/vcap_window_gen.sv
module vcap_window_gen #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             hsync_i,
   input  logic             vsync_i,
   input  logic             hpol_i,
   input  logic             vpol_i,
   input  logic [CNT_W-1:0] hstart_i,
   input  logic [CNT_W-1:0] hend_i,
   input  logic [CNT_W-1:0] vstart_i,
   input  logic [CNT_W-1:0] vend_i,
   output logic [CNT_W-1:0] pix_cnt_o,
   output logic [CNT_W-1:0] line_cnt_o,
   output logic             sample_en_o,
   output logic             line_first_o,
   output logic             field_first_o
);
   localparam int unsigned AXES  = 2;
   localparam int unsigned AX_H  = 0;
   localparam int unsigned AX_V  = 1;

   if (CNT_W < 2 || CNT_W > vcap_pkg::VCAP_MAX_W) begin : g_bad_width
      $error("vcap_window_gen: CNT_W out of range");
   end

   logic [AXES-1:0] sync_vec, pol_vec, edge_vec;
   logic            armed_q;

   assign sync_vec = {vsync_i, hsync_i};
   assign pol_vec  = {vpol_i, hpol_i};

   for (genvar a = 0; a < AXES; a++) begin : g_axis
      vcap_edge_det u_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .sync_i (sync_vec[a]),
         .pol_i  (pol_vec[a]),
         .edge_o (edge_vec[a])
      );
   end

   vcap_counter #(.CNT_W(CNT_W)) u_pix (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (edge_vec[AX_H]),
      .inc_i  (1'b1),
      .cnt_o  (pix_cnt_o)
   );

   vcap_counter #(.CNT_W(CNT_W)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (edge_vec[AX_V]),
      .inc_i  (edge_vec[AX_H]),
      .cnt_o  (line_cnt_o)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni)              armed_q <= 1'b0;
      else if (edge_vec[AX_V])  armed_q <= 1'b1;
   end

   vcap_window_cmp #(.CNT_W(CNT_W)) u_cmp (
      .armed_i       (armed_q),
      .pix_i         (pix_cnt_o),
      .line_i        (line_cnt_o),
      .hstart_i      (hstart_i),
      .hend_i        (hend_i),
      .vstart_i      (vstart_i),
      .vend_i        (vend_i),
      .sample_en_o   (sample_en_o),
      .line_first_o  (line_first_o),
      .field_first_o (field_first_o)
   );

   AST_UNARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed_q |-> !sample_en_o); // R1
   AST_LINE_FIRST_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_first_o |-> (sample_en_o && pix_cnt_o == hstart_i)); // R8
   AST_FIELD_FIRST_IN_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      field_first_o |-> (sample_en_o && line_cnt_o == vstart_i)); // R9
   AST_VEDGE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_vec[AX_V] |=> (line_cnt_o == '0 && armed_q)); // R5
endmodule

// File: tb/tb_vcap_window_gen.sv
module tb_vcap_window_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync = 1'b0, vsync = 1'b0, hpol = 1'b0, vpol = 1'b0;
   logic [9:0] hstart = 10'd1, hend = 10'h3FF, vstart = 10'd1, vend = 10'h3FF;
   logic [9:0] pix_cnt, line_cnt;
   logic sample_en, line_first, field_first;

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit done = 0;
   string tag = "R1";

   always #10 clk = ~clk;

   vcap_window_gen dut (
      .clk_i(clk), .rst_ni(rst_n), .hsync_i(hsync), .vsync_i(vsync),
      .hpol_i(hpol), .vpol_i(vpol), .hstart_i(hstart), .hend_i(hend),
      .vstart_i(vstart), .vend_i(vend), .pix_cnt_o(pix_cnt),
      .line_cnt_o(line_cnt), .sample_en_o(sample_en),
      .line_first_o(line_first), .field_first_o(field_first));

   // behavioural reference: history of sampled sync levels
   bit hhist[$];
   bit vhist[$];
   int m_pix = 1023, m_line = 1023;
   bit m_armed = 0;

   function automatic bit is_active(bit older, bit newer, bit pol);
      return pol ? (older && !newer) : (!older && newer);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         hhist = '{1'b0, 1'b0};
         vhist = '{1'b0, 1'b0};
         m_pix = 1023; m_line = 1023; m_armed = 0;
      end else begin
         bit he, ve;
         he = is_active(hhist[0], hhist[1], hpol);
         ve = is_active(vhist[0], vhist[1], vpol);
         m_pix = he ? 0 : (m_pix < 1023 ? m_pix + 1 : 1023);
         if (ve) begin m_line = 0; m_armed = 1; end
         else if (he && m_line < 1023) m_line = m_line + 1;
         hhist.push_back(hsync); void'(hhist.pop_front());
         vhist.push_back(vsync); void'(vhist.pop_front());
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
      end
   endtask

   task automatic compare_all();
      bit e_en;
      e_en = m_armed && (int'(hstart) <= m_pix) && (m_pix <= int'(hend)) &&
             (int'(vstart) <= m_line) && (m_line <= int'(vend));
      check("R4", "pix_cnt", int'(pix_cnt), m_pix);
      check("R5", "line_cnt", int'(line_cnt), m_line);
      check(tag, "sample_en", int'(sample_en), int'(e_en));
      check("R8", "line_first", int'(line_first), int'(e_en && m_pix == int'(hstart)));
      check("R9", "field_first", int'(field_first), int'(e_en && m_line == int'(vstart)));
   endtask

   task automatic step(bit h, bit v);
      @(negedge clk);
      if (rst_n) compare_all();
      hsync = h; vsync = v;
   endtask

   // one field: vsync active for the first 2 clocks, hsync active 2 clocks per line
   task automatic field(int lines, int ppl);
      for (int l = 0; l < lines; l++)
         for (int p = 0; p < ppl; p++)
            step((p < 2) ? !hpol : hpol, (l == 0 && p < 2) ? !vpol : vpol);
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      check("R1", "reset sample_en", int'(sample_en), 0);
      check("R4", "reset pix_cnt", int'(pix_cnt), 1023);
      check("R5", "reset line_cnt", int'(line_cnt), 1023);
      rst_n = 1'b1;
      // R1: lines without any vsync stay disabled, even with defaults
      tag = "R1";
      for (int l = 0; l < 4; l++)
         for (int p = 0; p < 20; p++) step(p < 2, 1'b0);
      check("R1", "unarmed sample_en", int'(sample_en), 0);

      // R6: small window, positive polarity
      tag = "R6"; hstart = 10'd3; hend = 10'd10; vstart = 10'd2; vend = 10'd5;
      field(8, 24); field(8, 24);

      // R6 boundary: start offsets of zero
      hstart = 10'd0; hend = 10'd4; vstart = 10'd0; vend = 10'd1;
      field(4, 16);

      // R2: negative HSYNC polarity, R3: negative VSYNC polarity
      tag = "R2"; hpol = 1'b1; hstart = 10'd2; hend = 10'd9; vstart = 10'd1; vend = 10'd4;
      for (int k = 0; k < 6; k++) step(1'b1, 1'b0);
      field(6, 20);
      tag = "R3"; vpol = 1'b1;
      for (int k = 0; k < 6; k++) step(1'b1, 1'b1);
      field(6, 20); field(6, 20);

      // R7: empty windows
      tag = "R7"; hstart = 10'd12; hend = 10'd5;
      field(6, 20);
      hstart = 10'd2; hend = 10'd9; vstart = 10'd4; vend = 10'd1;
      field(6, 20);

      // R4: pixel saturation on a long line
      tag = "R4"; hpol = 1'b0; vpol = 1'b0; vstart = 10'd0; vend = 10'd3;
      hstart = 10'd1000; hend = 10'h3FF;
      for (int k = 0; k < 6; k++) step(1'b0, 1'b0);
      field(2, 1100);
      check("R4", "saturated pix_cnt", int'(pix_cnt), 1023);

      // R5: line saturation with many short lines
      tag = "R5"; hstart = 10'd0; hend = 10'd2; vstart = 10'd1000; vend = 10'h3FF;
      field(1040, 4);
      check("R5", "saturated line_cnt", int'(line_cnt), 1023);

      done = 1;
      report();
   end
endmodule